// File: doc/BRIEF.md
# Bit-Level Pipelined Array Multiplier

This block multiplies an unsigned multiplicand by a multiplier held in the array, one new operand per clock. The array has one row of registered full-adder cells per multiplier bit. Each row adds one shifted partial product into a carry-save pair. Every cell has its own register for the multiplier bit of its row. The multiplicand moves down one row per cycle. The low product bits leave from the least-significant column of each row. A final row made of the same cell type, with its held bit fixed at 1, resolves the remaining carry-save pair as a bit-pipelined ripple adder. Skew registers in front of the array and deskew registers behind it let every operand enter whole in a single cycle and come out whole exactly `XW+RW` cycles later.

A mode input, sampled together with each operand, sets the boundary multiplexers. In functional mode the multiplicand port drives the array and every other boundary input is forced to 0. In test mode an external pattern source drives all boundary inputs of the array: the multiplicand column, the first row's sum and carry inputs, the top-column sum input of each later row, and the carry-in of the final adder. The pattern source and the response analyzer are outside this block and connect through the ports. The multiplier is loaded through a separate strobe and is held until the next load.

Top module: `sysmul_array`

## Requirements
- R1: While `rst_ni` is low, and after it is released, `valid_o` is 0 and `product_o` is 0. Reset clears the held multiplier to 0, so a functional operand issued after reset and before any load gives a product of 0.
- R2: `mult_i` is captured into the held multiplier on a clock edge where `load_i` is 1. The captured value stays until the next load. Changes on `mult_i` while `load_i` is 0 have no effect. Operands issued from the cycle after the load, and after any earlier operands have drained, use the new value.
- R3: In functional mode (`test_mode_i`=0), `product_o` equals `mcand_i * r`, where r is the held multiplier, for every multiplicand and multiplier value.
- R4: `valid_o` is 1 exactly `XW+RW` (7) cycles after a cycle in which `valid_i` was 1, and it is 0 otherwise. The product shown in that cycle belongs to that operand.
- R5: A new operand is accepted every cycle. Back-to-back operands give their own results in consecutive cycles.
- R6: In functional mode, `test_x_i`, `test_s_i`, `test_c_i`, `test_edge_i` and `test_cin_i` have no effect on the product.
- R7: In test mode (`test_mode_i`=1), `product_o` equals (`test_x_i`*r + `test_s_i` + `test_c_i` + the sum over m of `test_edge_i[m]`*2^(XW+m) + `test_cin_i`*2^RW) modulo 2^(XW+RW). Bit i of `test_s_i` and bit i of `test_c_i` each carry weight 2^i. Bit m of `test_edge_i` feeds the top-column sum input of row m+1.
- R8: The mode is sampled with each operand. Operands in alternating modes on consecutive cycles each give the result their own mode defines.
- R9: The product width holds the largest functional product (15*7 = 105) without loss. The carry out of the final adder is never 1 for a functional-mode operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Load strobe for the held multiplier |
| mult_i | input | RW (3) | Multiplier value captured on load |
| valid_i | input | 1 | Operand valid |
| mcand_i | input | XW (4) | Functional multiplicand |
| test_mode_i | input | 1 | 1 selects the test boundary inputs for this operand |
| test_x_i | input | XW (4) | Test multiplicand column inputs |
| test_s_i | input | XW (4) | Test sum inputs of the first row |
| test_c_i | input | XW (4) | Test carry inputs of the first row |
| test_edge_i | input | RW-1 (2) | Test top-column sum inputs of rows 1 to RW-1 |
| test_cin_i | input | 1 | Test carry-in of the final adder row |
| valid_o | output | 1 | Product valid |
| product_o | output | XW+RW (7) | Product |

## Verification
The bench builds the block with its default widths: a 4-bit multiplicand and a 3-bit multiplier. At these widths every functional operand pair (128 of them) can be streamed back to back and compared against a behavioural multiply. The test-mode sum stays small enough that injections at every boundary weight, and the wrap at 2^7, can be set up by hand in the vector table. The 7-cycle latency also keeps the mixed-mode streams short enough to check the alignment of each result with its own operand.

// File: rtl/sysmul_pkg.sv
package sysmul_pkg;

  typedef enum logic {
    MODE_FUNC = 1'b0,
    MODE_TEST = 1'b1
  } op_mode_e;

  function automatic logic fa_sum(input logic a, input logic b, input logic c);
    return a ^ b ^ c;
  endfunction

  function automatic logic fa_carry(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/sysmul_cell.sv
// Registered full-adder cell with its own held multiplier bit.
module sysmul_cell
  import sysmul_pkg::*;
#(
  parameter logic A_RST = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ld_i,
  input  logic r_i,
  input  logic x_i,
  input  logic s_i,
  input  logic c_i,
  output logic s_o,
  output logic c_o
);

  logic a_q;
  logic pp;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   a_q <= A_RST;
    else if (ld_i) a_q <= r_i;
  end

  assign pp = x_i & a_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s_o <= 1'b0;
      c_o <= 1'b0;
    end else begin
      s_o <= fa_sum(pp, s_i, c_i);
      c_o <= fa_carry(pp, s_i, c_i);
    end
  end

endmodule

// File: rtl/sysmul_dly.sv
// Fixed-depth delay line, DEPTH >= 1.
module sysmul_dly #(
  parameter int W     = 1,
  parameter int DEPTH = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] d_o
);

  logic [W-1:0] stg_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int d = 0; d < DEPTH; d++) stg_q[d] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int d = 1; d < DEPTH; d++) stg_q[d] <= stg_q[d-1];
    end
  end

  assign d_o = stg_q[DEPTH-1];

endmodule

// File: rtl/sysmul_bnd.sv
// Boundary multiplexers: functional operand or external test pattern.
module sysmul_bnd
  import sysmul_pkg::*;
#(
  parameter int XW = 4,
  parameter int RW = 3
) (
  input  op_mode_e        mode_i,
  input  logic [XW-1:0]   mcand_i,
  input  logic [XW-1:0]   tx_i,
  input  logic [XW-1:0]   ts_i,
  input  logic [XW-1:0]   tc_i,
  input  logic [RW-2:0]   te_i,
  input  logic            tcin_i,
  output logic [XW-1:0]   bx_o,
  output logic [XW-1:0]   bs_o,
  output logic [XW-1:0]   bc_o,
  output logic [RW-2:0]   be_o,
  output logic            bcin_o
);

  always_comb begin
    unique case (mode_i)
      MODE_TEST: begin
        bx_o   = tx_i;
        bs_o   = ts_i;
        bc_o   = tc_i;
        be_o   = te_i;
        bcin_o = tcin_i;
      end
      default: begin
        bx_o   = mcand_i;
        bs_o   = '0;
        bc_o   = '0;
        be_o   = '0;
        bcin_o = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/sysmul_array.sv
module sysmul_array
  import sysmul_pkg::*;
#(
  parameter int XW = 4,
  parameter int RW = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [RW-1:0]      mult_i,
  input  logic               valid_i,
  input  logic [XW-1:0]      mcand_i,
  input  logic               test_mode_i,
  input  logic [XW-1:0]      test_x_i,
  input  logic [XW-1:0]      test_s_i,
  input  logic [XW-1:0]      test_c_i,
  input  logic [RW-2:0]      test_edge_i,
  input  logic               test_cin_i,
  output logic               valid_o,
  output logic [XW+RW-1:0]   product_o
);

  localparam int PW = XW + RW;

  logic [XW-1:0] bx, bs, bc;
  logic [RW-2:0] be;
  logic          bcin;

  logic [RW-1:0][XW-1:0] s_q, c_q;
  logic [RW-2:0][XW-1:0] x_q;
  logic [RW-1:1]         edge_d;
  logic                  cin_d;
  logic [XW-1:0]         fin_a, fin_b, fin_s, fin_c;
  logic [PW-1:0]         prod_raw;
  logic [PW-1:0]         vld_q;

  sysmul_bnd #(.XW(XW), .RW(RW)) u_bnd (
    .mode_i (op_mode_e'(test_mode_i)),
    .mcand_i(mcand_i),
    .tx_i   (test_x_i),
    .ts_i   (test_s_i),
    .tc_i   (test_c_i),
    .te_i   (test_edge_i),
    .tcin_i (test_cin_i),
    .bx_o   (bx),
    .bs_o   (bs),
    .bc_o   (bc),
    .be_o   (be),
    .bcin_o (bcin)
  );

  // Carry-save rows: row j works on an operand j cycles after it entered.
  for (genvar j = 0; j < RW; j++) begin : g_row
    logic [XW-1:0] row_x, row_s, row_c;

    if (j == 0) begin : g_first
      assign row_x = bx;
      assign row_s = bs;
      assign row_c = bc;
    end else begin : g_next
      sysmul_dly #(.W(1), .DEPTH(j)) u_edge (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .d_i   (be[j-1]),
        .d_o   (edge_d[j])
      );
      assign row_x = x_q[j-1];
      assign row_s = {edge_d[j], s_q[j-1][XW-1:1]};
      assign row_c = c_q[j-1];
    end

    if (j < RW - 1) begin : g_xfwd
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) x_q[j] <= '0;
        else         x_q[j] <= row_x;
      end
    end

    for (genvar i = 0; i < XW; i++) begin : g_col
      sysmul_cell #(.A_RST(1'b0)) u_cell (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .ld_i  (load_i),
        .r_i   (mult_i[j]),
        .x_i   (row_x[i]),
        .s_i   (row_s[i]),
        .c_i   (row_c[i]),
        .s_o   (s_q[j][i]),
        .c_o   (c_q[j][i])
      );
    end

    assign prod_raw[j] = s_q[j][0];
  end

  // Final resolve row: same cell with held bit fixed at 1, bit-pipelined ripple.
  sysmul_dly #(.W(1), .DEPTH(RW)) u_cin (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (bcin),
    .d_o   (cin_d)
  );

  for (genvar k = 0; k < XW; k++) begin : g_fin
    logic ripple_in;

    if (k == XW - 1) begin : g_msb
      sysmul_dly #(.W(1), .DEPTH(k)) u_skew (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .d_i   (c_q[RW-1][k]),
        .d_o   (fin_b[k])
      );
      assign fin_a[k] = 1'b0;
    end else if (k == 0) begin : g_lsb
      assign fin_a[k] = s_q[RW-1][k+1];
      assign fin_b[k] = c_q[RW-1][k];
    end else begin : g_mid
      sysmul_dly #(.W(2), .DEPTH(k)) u_skew (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .d_i   ({s_q[RW-1][k+1], c_q[RW-1][k]}),
        .d_o   ({fin_a[k], fin_b[k]})
      );
    end

    if (k == 0) begin : g_c0
      assign ripple_in = cin_d;
    end else begin : g_cn
      assign ripple_in = fin_c[k-1];
    end

    sysmul_cell #(.A_RST(1'b1)) u_cell (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .ld_i  (1'b0),
      .r_i   (1'b0),
      .x_i   (fin_a[k]),
      .s_i   (fin_b[k]),
      .c_i   (ripple_in),
      .s_o   (fin_s[k]),
      .c_o   (fin_c[k])
    );

    assign prod_raw[RW+k] = fin_s[k];
  end

  // Deskew: bit b appears b+1 cycles after entry; align all to PW.
  for (genvar b = 0; b < PW; b++) begin : g_out
    if (b == PW - 1) begin : g_direct
      assign product_o[b] = prod_raw[b];
    end else begin : g_align
      sysmul_dly #(.W(1), .DEPTH(PW - 1 - b)) u_align (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .d_i   (prod_raw[b]),
        .d_o   (product_o[b])
      );
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_q <= '0;
    else         vld_q <= {vld_q[PW-2:0], valid_i};
  end

  assign valid_o = vld_q[PW-1];

endmodule

// File: rtl/sysmul_chk.sv
module sysmul_chk #(
  parameter int XW = 4,
  parameter int RW = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               load_i,
  input logic [RW-1:0]      mult_i,
  input logic               valid_i,
  input logic [XW-1:0]      mcand_i,
  input logic               test_mode_i,
  input logic [XW-1:0]      test_x_i,
  input logic [XW-1:0]      test_s_i,
  input logic [XW-1:0]      test_c_i,
  input logic [RW-2:0]      test_edge_i,
  input logic               test_cin_i,
  input logic               valid_o,
  input logic [XW+RW-1:0]   product_o,
  input logic               fin_carry_i
);

  localparam int PW   = XW + RW;
  localparam int SW   = $clog2(PW + 1);
  localparam int MAXP = ((1 << XW) - 1) * ((1 << RW) - 1);

  logic [RW-1:0] r_sh;
  logic [SW-1:0] since_ld;
  logic [PW-1:0] vp_q, mp_q;
  logic [PW-1:0] ep_q [PW];
  logic [PW-1:0] exp_now;
  int            acc;

  always_comb begin
    if (test_mode_i) begin
      acc = int'(test_x_i) * int'(r_sh) + int'(test_s_i) + int'(test_c_i)
            + (int'(test_cin_i) << RW);
      for (int m = 0; m < RW - 1; m++)
        if (test_edge_i[m]) acc = acc + (1 << (XW + m));
    end else begin
      acc = int'(mcand_i) * int'(r_sh);
    end
    exp_now = acc[PW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      r_sh     <= '0;
      since_ld <= '0;
      vp_q     <= '0;
      mp_q     <= '0;
      for (int d = 0; d < PW; d++) ep_q[d] <= '0;
    end else begin
      if (load_i) begin
        r_sh     <= mult_i;
        since_ld <= '0;
      end else if (since_ld < SW'(PW)) begin
        since_ld <= since_ld + 1'b1;
      end
      vp_q  <= {vp_q[PW-2:0], valid_i};
      mp_q  <= {mp_q[PW-2:0], test_mode_i};
      ep_q[0] <= exp_now;
      for (int d = 1; d < PW; d++) ep_q[d] <= ep_q[d-1];
    end
  end

  AST_VALID_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == vp_q[PW-1]); // R4

  AST_FUNC_PRODUCT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !mp_q[PW-1] && since_ld >= SW'(PW)) |-> product_o == ep_q[PW-1]); // R3

  AST_TEST_PRODUCT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && mp_q[PW-1] && since_ld >= SW'(PW)) |-> product_o == ep_q[PW-1]); // R7

  AST_NO_FINAL_CARRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mp_q[PW-1] |-> !fin_carry_i); // R9

  AST_FUNC_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !mp_q[PW-1]) |-> int'(product_o) <= MAXP); // R9

endmodule

bind sysmul_array sysmul_chk #(.XW(XW), .RW(RW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .load_i     (load_i),
  .mult_i     (mult_i),
  .valid_i    (valid_i),
  .mcand_i    (mcand_i),
  .test_mode_i(test_mode_i),
  .test_x_i   (test_x_i),
  .test_s_i   (test_s_i),
  .test_c_i   (test_c_i),
  .test_edge_i(test_edge_i),
  .test_cin_i (test_cin_i),
  .valid_o    (valid_o),
  .product_o  (product_o),
  .fin_carry_i(fin_c[XW-1])
);

// File: tb/tb_sysmul_array.sv
`timescale 1ns/1ps
module tb_sysmul_array;

  localparam int XW = 4;
  localparam int RW = 3;
  localparam int PW = XW + RW;

  // {mode, r[2:0], x[3:0], s[3:0], c[3:0], edge[1:0], cin, expected[6:0]}
  localparam logic [25:0] TBL [10] = '{
    {1'b0, 3'd7, 4'd15, 4'd15, 4'd15, 2'd3, 1'b1, 7'd105},
    {1'b0, 3'd5, 4'd9,  4'd0,  4'd0,  2'd0, 1'b0, 7'd45},
    {1'b0, 3'd0, 4'd15, 4'd7,  4'd1,  2'd2, 1'b1, 7'd0},
    {1'b1, 3'd0, 4'd0,  4'd0,  4'd0,  2'd0, 1'b1, 7'd8},
    {1'b1, 3'd3, 4'd5,  4'd1,  4'd2,  2'd0, 1'b0, 7'd18},
    {1'b1, 3'd7, 4'd15, 4'd15, 4'd15, 2'd3, 1'b1, 7'd63},
    {1'b1, 3'd1, 4'd0,  4'd0,  4'd0,  2'd1, 1'b0, 7'd16},
    {1'b1, 3'd2, 4'd0,  4'd0,  4'd0,  2'd2, 1'b0, 7'd32},
    {1'b1, 3'd6, 4'd10, 4'd4,  4'd3,  2'd0, 1'b1, 7'd75},
    {1'b0, 3'd1, 4'd1,  4'd8,  4'd8,  2'd1, 1'b0, 7'd1}
  };

  logic          clk_i = 1'b0;
  logic          rst_ni;
  logic          load_i;
  logic [RW-1:0] mult_i;
  logic          valid_i;
  logic [XW-1:0] mcand_i;
  logic          test_mode_i;
  logic [XW-1:0] test_x_i, test_s_i, test_c_i;
  logic [RW-2:0] test_edge_i;
  logic          test_cin_i;
  logic          valid_o;
  logic [PW-1:0] product_o;

  sysmul_array #(.XW(XW), .RW(RW)) dut (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load_i),
    .mult_i     (mult_i),
    .valid_i    (valid_i),
    .mcand_i    (mcand_i),
    .test_mode_i(test_mode_i),
    .test_x_i   (test_x_i),
    .test_s_i   (test_s_i),
    .test_c_i   (test_c_i),
    .test_edge_i(test_edge_i),
    .test_cin_i (test_cin_i),
    .valid_o    (valid_o),
    .product_o  (product_o)
  );

  always #10 clk_i = ~clk_i;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int head   = 0;
  int tail   = 0;
  logic [PW-1:0] exp_q [512];
  int            iss_q [512];
  string         tag_q [512];
  bit            done = 1'b0;

  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, expv, cyc);
    end
  endtask

  // Result monitor: value and latency of each output (R4)
  always @(negedge clk_i) begin
    if (rst_ni && valid_o) begin
      if (head == tail) begin
        chk(1'b0, "R4 unexpected valid_o", 1, 0);
      end else begin
        chk(product_o == exp_q[head % 512], tag_q[head % 512],
            int'(product_o), int'(exp_q[head % 512]));
        chk(cyc - iss_q[head % 512] == PW, "R4 latency",
            cyc - iss_q[head % 512], PW);
        head++;
      end
    end
  end

  function automatic int model(input bit mode, input int r, input int x, input int s,
                               input int c, input int e, input int cin);
    int v;
    if (mode) v = x * r + s + c + ((e & 1) << XW) + (((e >> 1) & 1) << (XW + 1)) + (cin << RW);
    else      v = x * r;
    return v % (1 << PW);
  endfunction

  task automatic issue(input bit mode, input int x, input int s, input int c, input int e,
                       input int cin, input int expv, input string tag);
    @(negedge clk_i);
    valid_i     = 1'b1;
    test_mode_i = mode;
    mcand_i     = XW'(x);
    test_x_i    = XW'(x);
    test_s_i    = XW'(s);
    test_c_i    = XW'(c);
    test_edge_i = (RW-1)'(e);
    test_cin_i  = cin[0];
    exp_q[tail % 512] = PW'(expv);
    iss_q[tail % 512] = cyc;
    tag_q[tail % 512] = tag;
    tail++;
  endtask

  task automatic drain();
    @(negedge clk_i);
    valid_i = 1'b0;
    for (int w = 0; w < 4 * PW && head != tail; w++) @(negedge clk_i);
    chk(head == tail, "R4 results outstanding", tail - head, 0);
    @(negedge clk_i);
  endtask

  task automatic load_r(input int r);
    @(negedge clk_i);
    valid_i = 1'b0;
    load_i  = 1'b1;
    mult_i  = RW'(r);
    @(negedge clk_i);
    load_i  = 1'b0;
    mult_i  = ~RW'(r);  // must be ignored while load_i is low (R2)
  endtask

  initial begin
    rst_ni = 1'b0;
    load_i = 1'b0; mult_i = '0; valid_i = 1'b0; mcand_i = '0;
    test_mode_i = 1'b0; test_x_i = '0; test_s_i = '0; test_c_i = '0;
    test_edge_i = '0; test_cin_i = 1'b0;

    repeat (3) @(negedge clk_i);
    chk(valid_o == 1'b0, "R1 valid_o in reset", int'(valid_o), 0);
    chk(product_o == '0, "R1 product_o in reset", int'(product_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(valid_o == 1'b0, "R1 valid_o after reset", int'(valid_o), 0);
    chk(product_o == '0, "R1 product_o after reset", int'(product_o), 0);

    // R1: held multiplier is 0 after reset
    issue(1'b0, 15, 0, 0, 0, 0, 0, "R1 product with cleared multiplier");
    drain();

    // Vector table: functional rows show R3/R6, test rows show R7
    for (int n = 0; n < 10; n++) begin
      logic [25:0] ent;
      ent = TBL[n];
      load_r(int'(ent[24:22]));
      issue(ent[25], int'(ent[21:18]), int'(ent[17:14]), int'(ent[13:10]),
            int'(ent[9:8]), int'(ent[7]), int'(ent[6:0]),
            ent[25] ? "R7 table test-mode vector" : "R6 table functional vector");
      drain();
    end

    // R2 and R8: mode alternates per operand; mult_i is driven with other values meanwhile
    load_r(5);
    issue(1'b0, 3, 0, 0, 0, 0, model(1'b0, 5, 3, 0, 0, 0, 0), "R2 held multiplier");
    mult_i = 3'd2;
    issue(1'b1, 2, 1, 0, 0, 0, model(1'b1, 5, 2, 1, 0, 0, 0), "R8 test after functional");
    issue(1'b0, 15, 9, 9, 3, 1, model(1'b0, 5, 15, 9, 9, 3, 1), "R8 functional after test");
    issue(1'b1, 0, 0, 0, 3, 1, model(1'b1, 5, 0, 0, 0, 3, 1), "R8 edge and carry-in weights");
    issue(1'b0, 9, 0, 0, 0, 0, model(1'b0, 5, 9, 0, 0, 0, 0), "R8 functional tail");
    drain();

    // R3 and R5: all operand pairs, streamed back to back
    for (int r = 0; r < (1 << RW); r++) begin
      load_r(r);
      for (int x = 0; x < (1 << XW); x++)
        issue(1'b0, x, x, 15 - x, 3, x & 1, x * r, "R3 R5 exhaustive multiply");
      drain();
    end

    // R9: largest product uses the top bit without loss
    load_r(7);
    issue(1'b0, 15, 0, 0, 0, 0, 105, "R9 largest product");
    drain();

    // R4: no valid_o without an operand
    for (int w = 0; w < 10; w++) begin
      @(negedge clk_i);
      chk(valid_o == 1'b0, "R4 idle valid_o", int'(valid_o), 0);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R4 watchdog expired actual=%0d expected=%0d", cyc, 20000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule